// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog that runs from the 32.768 kHz low-speed clock. It begins counting when its reset is released and has no control that stops it. Software chooses one of four timeout lengths, which at the default base of 4096 cycles are about 125 ms, 500 ms, 2 s and 8 s. If software lets one timeout pass without servicing the watchdog, the block sends a one-cycle non-maskable interrupt request. If a second timeout then passes with still no service, it raises a system reset request. That request stays high until the block's own reset is applied.

Software uses a write-only register port with two targets, chosen by `wr_sel`. Target 0 holds the period select. Target 1 is the clear-key register. Servicing takes two consecutive writes to the clear-key register: 0x3C and then 0xC3. A correct pair zeroes the counter and clears the first-overflow flag. It also loads the most recently written period select, so a period change never shortens or stretches a timeout that is already running. The port carries no data stream. There is no valid/ready handshake and no back-pressure: every write is taken on the clock edge where `wr_en` is high.

Top module: `wdog_two_stage`

## Requirements
- R1: While reset is held, and right after it is released, `ovf_flag`, `nmi_pulse` and `rst_req` are 0, the counter is zero and period code 0 is in force.
- R2: Period code c (0 to 3) gives a timeout of BASE_CYCLES·4^c clock cycles. The first overflow is seen on the L-th rising edge after reset release or after the edge that completes a service, where L is the timeout length.
- R3: On an overflow while `ovf_flag` is 0, `nmi_pulse` is 1 for exactly one cycle, following that edge. `ovf_flag` becomes 1 and `rst_req` stays 0.
- R4: On an overflow while `ovf_flag` is already 1, `rst_req` becomes 1 and stays 1 until reset. That overflow and any later overflow give no `nmi_pulse`.
- R5: With `wr_sel`=1, a write of 0x3C followed by a write of 0xC3 as the next clear-key write is a service. The service zeroes the counter and clears `ovf_flag`. A service on the same edge as an overflow wins, and no overflow action is taken.
- R6: A 0xC3 write with no 0x3C immediately before it among clear-key writes has no effect. So does a pair with any other value written between them. A repeated 0x3C keeps the sequence armed.
- R7: Writes with `wr_sel`=0 neither break nor complete a clear-key sequence.
- R8: A period code written with `wr_sel`=0 (taken from `wr_data[1:0]`) takes effect only at the next service. The current timeout keeps its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_lsc | input | 1 | Low-speed clock, 32.768 kHz |
| rst_lsc_n | input | 1 | Asynchronous active-low reset of the block |
| wr_en | input | 1 | Register write strobe, one write per high cycle |
| wr_sel | input | 1 | Write target: 0 period select, 1 clear key |
| wr_data | input | 8 | Write data; bits 1:0 hold the period code for target 0 |
| ovf_flag | output | 1 | First-overflow status, cleared only by a service |
| nmi_pulse | output | 1 | One-cycle non-maskable interrupt request |
| rst_req | output | 1 | Sticky system reset request |

## Verification
A write completes on the rising edge where `wr_en` is high. A service therefore clears `ovf_flag` in the cycle that follows that edge. An overflow shows on `nmi_pulse` or `rst_req` in the cycle after the L-th edge counted from reset release or from the servicing edge. The bench counts rising edges from reset release and drives and samples only on falling edges. Each expected pulse is checked at three points: one edge before the computed edge (must be low), right after it (must be high), and one edge later (must be low again). The short timeouts in the bench come from overriding the base cycle count, so the same edge arithmetic covers all four period codes.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef logic [1:0] per_code_t;

  localparam logic [7:0] KEY_ARM  = 8'h3C;
  localparam logic [7:0] KEY_FIRE = 8'hC3;

  localparam logic REG_PERIOD = 1'b0;
  localparam logic REG_CLEAR  = 1'b1;

  localparam int unsigned NUM_CODES = 4;

  function automatic int unsigned per_cycles(int unsigned base, int unsigned code);
    return base << (2 * code);
  endfunction
endpackage

// File: rtl/wdog_period.sv
module wdog_period
  import wdog_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic      wr_sel,
  input  per_code_t wr_code,
  input  logic      svc,
  output per_code_t code_act
);
  per_code_t code_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_pend <= '0;
      code_act  <= '0;
    end else begin
      if (wr_en && wr_sel == REG_PERIOD) code_pend <= wr_code;
      if (svc) code_act <= code_pend;
    end
  end

  // R8
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !svc |=> $stable(code_act));
endmodule

// File: rtl/wdog_clr_key.sv
module wdog_clr_key
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output logic       svc
);
  logic armed;
  logic key_wr;

  assign key_wr = wr_en && (wr_sel == REG_CLEAR);
  assign svc    = key_wr && armed && (wr_data == KEY_FIRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed <= 1'b0;
    else if (key_wr) armed <= (wr_data == KEY_ARM);
  end

  // R5
  svc_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc |=> !armed);
  // R7
  key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == REG_CLEAR) |=> $stable(armed));
endmodule

// File: rtl/wdog_tick.sv
module wdog_tick
  import wdog_pkg::*;
#(
  parameter int unsigned BASE_CYCLES = 4096
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      svc,
  input  per_code_t code,
  output logic      ovf
);
  localparam int unsigned MAX_CYC = BASE_CYCLES << 6;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC);

  logic [CNT_W-1:0] lim_tab [NUM_CODES];
  logic [CNT_W-1:0] cnt;

  for (genvar k = 0; k < NUM_CODES; k++) begin : g_lim
    assign lim_tab[k] = CNT_W'(per_cycles(BASE_CYCLES, k) - 1);
  end

  assign ovf = (cnt == lim_tab[code]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (svc || ovf) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= lim_tab[code]);
  // R5
  svc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc |=> cnt == '0);
endmodule

// File: rtl/wdog_stage.sv
module wdog_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf,
  input  logic svc,
  output logic flag,
  output logic nmi,
  output logic rst_req
);
  logic hit;
  assign hit = ovf && !svc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag    <= 1'b0;
      nmi     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      nmi <= hit && !flag;
      if (hit && flag) rst_req <= 1'b1;
      if (svc)         flag <= 1'b0;
      else if (hit)    flag <= 1'b1;
    end
  end

  // R3
  nmi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |=> !nmi);
  // R3
  nmi_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |-> flag);
  // R4
  rst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);
  // R4
  rst_after_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(flag));
  // R5
  svc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc |=> !flag);
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int unsigned BASE_CYCLES = 4096
) (
  input  logic       clk_lsc,
  input  logic       rst_lsc_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  output logic       ovf_flag,
  output logic       nmi_pulse,
  output logic       rst_req
);
  logic      svc;
  logic      ovf;
  per_code_t code_act;

  wdog_clr_key i_key (
    .clk(clk_lsc), .rst_n(rst_lsc_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .svc(svc)
  );

  wdog_period i_period (
    .clk(clk_lsc), .rst_n(rst_lsc_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_code(wr_data[1:0]), .svc(svc), .code_act(code_act)
  );

  wdog_tick #(.BASE_CYCLES(BASE_CYCLES)) i_tick (
    .clk(clk_lsc), .rst_n(rst_lsc_n), .svc(svc), .code(code_act), .ovf(ovf)
  );

  wdog_stage i_stage (
    .clk(clk_lsc), .rst_n(rst_lsc_n), .ovf(ovf), .svc(svc),
    .flag(ovf_flag), .nmi(nmi_pulse), .rst_req(rst_req)
  );
endmodule

// File: tb/test_wdog_two_stage.sv
module test_wdog_two_stage;
  localparam int BASE = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic ovf_flag, nmi_pulse, rst_req;

  int edges = 0;
  int base_e = 0;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) edges <= edges + 1;

  wdog_two_stage #(.BASE_CYCLES(BASE)) i_wdog_two_stage (
    .clk_lsc(clk), .rst_lsc_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .ovf_flag(ovf_flag), .nmi_pulse(nmi_pulse), .rst_req(rst_req)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at edge %0d: actual %0b expected %0b", req, what, edges - base_e, act, exp);
    end
  endtask

  task automatic goto_edge(int e);
    while (edges - base_e < e) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    base_e = edges;
  endtask

  task automatic write_at(int e, logic sel, logic [7:0] d);
    goto_edge(e - 1);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    goto_edge(e);
    wr_en = 1'b0;
  endtask

  task automatic check_nmi_at(string req, int e, logic exp);
    goto_edge(e - 1);
    chk(req, "nmi before edge", nmi_pulse, 1'b0);
    goto_edge(e);
    chk(req, "nmi at edge", nmi_pulse, exp);
    goto_edge(e + 1);
    chk(req, "nmi after edge", nmi_pulse, 1'b0);
  endtask

  // R1
  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "flag in reset", ovf_flag, 1'b0);
    chk("R1", "nmi in reset", nmi_pulse, 1'b0);
    chk("R1", "rst_req in reset", rst_req, 1'b0);
    do_reset();
    goto_edge(1);
    chk("R1", "flag after release", ovf_flag, 1'b0);
    chk("R1", "rst_req after release", rst_req, 1'b0);
  endtask

  // R2 R3
  task automatic t_first();
    do_reset();
    check_nmi_at("R2", 16, 1'b1);
    chk("R3", "flag set", ovf_flag, 1'b1);
    chk("R3", "no reset", rst_req, 1'b0);
  endtask

  // R4
  task automatic t_second();
    do_reset();
    check_nmi_at("R3", 16, 1'b1);
    goto_edge(31);
    chk("R4", "rst_req early", rst_req, 1'b0);
    goto_edge(32);
    chk("R4", "rst_req set", rst_req, 1'b1);
    chk("R4", "no second nmi", nmi_pulse, 1'b0);
    goto_edge(48);
    chk("R4", "no third nmi", nmi_pulse, 1'b0);
    goto_edge(100);
    chk("R4", "rst_req sticky", rst_req, 1'b1);
  endtask

  // R5
  task automatic t_service();
    do_reset();
    write_at(14, 1'b1, 8'h3C);
    write_at(15, 1'b1, 8'hC3);
    check_nmi_at("R5", 16, 1'b0);
    check_nmi_at("R5", 31, 1'b1);
    do_reset();
    write_at(15, 1'b1, 8'h3C);
    write_at(16, 1'b1, 8'hC3);
    chk("R5", "service wins flag", ovf_flag, 1'b0);
    chk("R5", "service wins nmi", nmi_pulse, 1'b0);
    check_nmi_at("R5", 32, 1'b1);
  endtask

  // R5
  task automatic t_clear_flag();
    do_reset();
    check_nmi_at("R5", 16, 1'b1);
    write_at(20, 1'b1, 8'h3C);
    chk("R5", "flag held before key", ovf_flag, 1'b1);
    write_at(21, 1'b1, 8'hC3);
    chk("R5", "flag cleared", ovf_flag, 1'b0);
    check_nmi_at("R5", 37, 1'b1);
    chk("R5", "no reset after service", rst_req, 1'b0);
  endtask

  // R6
  task automatic t_broken();
    do_reset();
    write_at(5, 1'b1, 8'h3C);
    write_at(6, 1'b1, 8'h55);
    write_at(7, 1'b1, 8'hC3);
    check_nmi_at("R6", 16, 1'b1);
    do_reset();
    write_at(5, 1'b1, 8'hC3);
    check_nmi_at("R6", 16, 1'b1);
    do_reset();
    write_at(5, 1'b1, 8'h3C);
    write_at(6, 1'b1, 8'h3C);
    write_at(7, 1'b1, 8'hC3);
    check_nmi_at("R6", 16, 1'b0);
    check_nmi_at("R6", 23, 1'b1);
  endtask

  // R7 R8
  task automatic t_period_between();
    do_reset();
    write_at(5, 1'b1, 8'h3C);
    write_at(6, 1'b0, 8'h01);
    write_at(7, 1'b1, 8'hC3);
    check_nmi_at("R7", 23, 1'b0);
    check_nmi_at("R7", 71, 1'b1);
  endtask

  // R8
  task automatic t_deferred();
    do_reset();
    write_at(3, 1'b0, 8'h01);
    check_nmi_at("R8", 16, 1'b1);
    write_at(19, 1'b1, 8'h3C);
    write_at(20, 1'b1, 8'hC3);
    check_nmi_at("R8", 36, 1'b0);
    check_nmi_at("R8", 84, 1'b1);
    chk("R8", "no reset", rst_req, 1'b0);
  endtask

  // R2
  task automatic t_long();
    do_reset();
    write_at(2, 1'b0, 8'h02);
    write_at(3, 1'b1, 8'h3C);
    write_at(4, 1'b1, 8'hC3);
    check_nmi_at("R2", 260, 1'b1);
    do_reset();
    write_at(2, 1'b0, 8'h03);
    write_at(3, 1'b1, 8'h3C);
    write_at(4, 1'b1, 8'hC3);
    check_nmi_at("R2", 1028, 1'b1);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_first();
    t_second();
    t_service();
    t_clear_flag();
    t_broken();
    t_period_between();
    t_deferred();
    t_long();
    summary();
  end

  initial begin
    #(20 * 150000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired: actual hung expected done");
    summary();
  end
endmodule